// File: doc/BRIEF.md
# Variable-Rate Third-Order CIC Interpolator Bank

This block is a bank of independent interpolating filters, one per output channel. Each channel takes 16-bit unsigned samples at a low, programmable rate. On every frame tick it produces one filtered value, so it raises the sample rate by an integer factor R. The filter has a comb section that runs once per input period and a zero-order hold up to the frame rate. After these come three cascaded integrators that run once per frame. A programmable arithmetic right shift scales the result back to the output range, and the output saturates to 16 bits.

The rate is coded as a small float: a 6-bit mantissa and a 4-bit exponent. One shared register holds a staged setting. The setting reaches a channel only when a mask-selected apply is issued. The apply clears that channel's filter state, restarts its input period at the next frame tick, and hides the output until the filter has taken in three input samples. Each channel takes at most one sample per input period. Any further sample in that period is dropped and counted.

Top module: `cic_interp_bank`

## Requirements
- R1: While reset is held and right after it is released, every out_valid bit is 0, out_data is 0 and every drop_count is 0.
- R2: A staged setting is a 16-bit word with mantissa m in bits [5:0], exponent e in bits [9:6] and shift g in bits [15:10]. It is written with stage_we and has no effect on any channel until an apply. An apply loads it into exactly the channels whose apply_mask bit is 1. The other channels keep their setting, state and outputs.
- R3: A channel's period boundaries fall on the 1st frame tick after its apply and then on every R-th tick, where R = (m+1)·2^e. A frame tick in the same cycle as that channel's apply is ignored by that channel.
- R4: After an apply, a channel asserts no out_valid until the frame tick of its 4th period boundary, which is tick 3R+1. The first three input periods are absorbed without output.
- R5: At R = 1 and g = 0, each frame tick outputs exactly the sample taken in at that tick's boundary, for any 16-bit value including 0 and 0xFFFF.
- R6: For a constant input x, once the filter has settled, the output is floor(x·R³ / 2^g).
- R7: A scaled result above 0xFFFF is output as 0xFFFF.
- R8: out_valid is a one-cycle pulse in the cycle after a frame tick, and out_data holds its value between pulses. With the channel's cont_mask bit at 1, a settled channel pulses on every frame tick. With the bit at 0, it pulses only on boundary ticks.
- R9: A second sample in the same input period is discarded. The channel's drop_count goes up by one, wrapping at its width, and the discarded value never reaches the output.
- R10: A sample that arrives in the same cycle as a boundary tick is not dropped. It fills the slot of the period that begins at that tick, and it is taken in at the next boundary.
- R11: If no sample arrives during a period, the next boundary takes in the previous sample again. After an apply, that previous sample is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe, one per output frame |
| stage_we | input | 1 | Writes stage_data into the staged setting |
| stage_data | input | 16 | Staged setting word {g, e, m} |
| apply_we | input | 1 | Applies the staged setting to the masked channels |
| apply_mask | input | NCH | Channel selection for an apply |
| cont_mask | input | NCH | Per-channel output on every frame tick |
| smp_valid | input | NCH | Per-channel sample strobe |
| smp_data | input | NCH*16 | Per-channel samples, channel c at [16c+15:16c] |
| out_valid | output | NCH | Per-channel output pulse |
| out_data | output | NCH*16 | Per-channel filtered output |
| drop_count | output | NCH*DROPW | Per-channel count of discarded samples |

## Verification
The collision that matters is a sample strobe in the same cycle as a period-boundary tick. In that cycle the slot is being emptied into the comb while it is also being refilled. The bench applies a fresh setting, drives the sample together with the first boundary tick, and then sends a second sample within that period. The first sample must leave drop_count unchanged and the second must raise it by one. The output must then follow the arithmetic step response of the first sample, never the second. The same bench also issues an apply together with a frame tick and checks that the first output comes one tick later than it would if that tick had counted.

// File: rtl/cic_interp_pkg.sv
package cic_interp_pkg;

   localparam int MANT_W = 6;
   localparam int REXP_W = 4;
   localparam int GAIN_W = 6;

   typedef struct packed {
      logic [GAIN_W-1:0] gain;
      logic [REXP_W-1:0] rexp;
      logic [MANT_W-1:0] mant;
   } cic_cfg_t;

   localparam int CFG_W  = $bits(cic_cfg_t);
   localparam int RATE_W = MANT_W + 1 + (2**REXP_W) - 1;

   localparam cic_cfg_t CFG_UNITY = '0;

   // interpolation factor minus one: ((mant + 1) << rexp) - 1
   function automatic logic [RATE_W-1:0] rate_minus1(input cic_cfg_t c);
      logic [RATE_W-1:0] r;
      r = ({{(RATE_W-MANT_W){1'b0}}, c.mant} + RATE_W'(1)) << c.rexp;
      return r - RATE_W'(1);
   endfunction

endpackage

// File: rtl/cic_rate_ctr.sv
module cic_rate_ctr
   import cic_interp_pkg::*;
#(
   parameter int ORDER = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   input  logic [RATE_W-1:0] rate_m1,
   output logic              bnd,
   output logic              ready
);

   localparam int SET_W = $clog2(ORDER + 2);
   localparam logic [SET_W-1:0] SETTLE_INIT = SET_W'(ORDER + 1);

   logic [RATE_W-1:0] cnt;
   logic [SET_W-1:0]  settle;
   logic [SET_W-1:0]  settle_nxt;

   assign bnd = tick && (cnt == '0);

   always_comb begin
      settle_nxt = settle;
      if (bnd && (settle != '0)) begin
         settle_nxt = settle - 1'b1;
      end
   end

   assign ready = (settle_nxt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         settle <= SETTLE_INIT;
      end else if (clr) begin
         cnt    <= '0;
         settle <= SETTLE_INIT;
      end else if (tick) begin
         cnt    <= bnd ? rate_m1 : cnt - 1'b1;
         settle <= settle_nxt;
      end
   end

endmodule

// File: rtl/cic_core.sv
module cic_core #(
   parameter int DW    = 16,
   parameter int ORDER = 3,
   parameter int ACCW  = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   tick,
   input  logic                   bnd,
   input  logic [DW-1:0]          x_in,
   output logic signed [ACCW-1:0] acc
);

   typedef logic signed [ACCW-1:0] acc_t;

   acc_t cin   [ORDER+1];
   acc_t cdly  [ORDER];
   acc_t integ [ORDER];
   acc_t isum  [ORDER];
   acc_t held;
   acc_t hold_v;

   assign cin[0] = acc_t'({{(ACCW-DW){1'b0}}, x_in});

   for (genvar k = 0; k < ORDER; k++) begin : g_comb
      assign cin[k+1] = cin[k] - cdly[k];
   end

   // zero-order hold of the comb output up to the frame rate
   assign hold_v = bnd ? cin[ORDER] : held;

   for (genvar k = 0; k < ORDER; k++) begin : g_integ
      if (k == 0) begin : g_first
         assign isum[k] = integ[k] + hold_v;
      end else begin : g_next
         assign isum[k] = integ[k] + isum[k-1];
      end
   end

   assign acc = isum[ORDER-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= '0;
         for (int k = 0; k < ORDER; k++) begin
            cdly[k]  <= '0;
            integ[k] <= '0;
         end
      end else if (clr) begin
         held <= '0;
         for (int k = 0; k < ORDER; k++) begin
            cdly[k]  <= '0;
            integ[k] <= '0;
         end
      end else if (tick) begin
         if (bnd) begin
            held <= cin[ORDER];
            for (int k = 0; k < ORDER; k++) begin
               cdly[k] <= cin[k];
            end
         end
         for (int k = 0; k < ORDER; k++) begin
            integ[k] <= isum[k];
         end
      end
   end

endmodule

// File: rtl/cic_gain_sat.sv
module cic_gain_sat #(
   parameter int DW     = 16,
   parameter int ACCW   = 64,
   parameter int SHW    = 6,
   parameter bit SAT_EN = 1'b1
) (
   input  logic signed [ACCW-1:0] acc,
   input  logic [SHW-1:0]         shamt,
   output logic [DW-1:0]          y
);

   localparam logic signed [ACCW-1:0] MAXV = {{(ACCW-DW){1'b0}}, {DW{1'b1}}};

   logic signed [ACCW-1:0] sh;

   assign sh = acc >>> shamt;

   if (SAT_EN) begin : g_sat
      always_comb begin
         if (sh[ACCW-1]) begin
            y = '0;
         end else if (sh > MAXV) begin
            y = '1;
         end else begin
            y = sh[DW-1:0];
         end
      end
   end else begin : g_wrap
      assign y = sh[DW-1:0];
   end

endmodule

// File: rtl/cic_interp_bank.sv
module cic_interp_bank
   import cic_interp_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int DW     = 16,
   parameter int ORDER  = 3,
   parameter int GROW_W = 16,
   parameter int DROPW  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_tick,
   input  logic                 stage_we,
   input  logic [CFG_W-1:0]     stage_data,
   input  logic                 apply_we,
   input  logic [NCH-1:0]       apply_mask,
   input  logic [NCH-1:0]       cont_mask,
   input  logic [NCH-1:0]       smp_valid,
   input  logic [NCH*DW-1:0]    smp_data,
   output logic [NCH-1:0]       out_valid,
   output logic [NCH*DW-1:0]    out_data,
   output logic [NCH*DROPW-1:0] drop_count
);

   localparam int ACCW = DW + ORDER * GROW_W;

   if (NCH < 1) begin : g_bad_nch
      $error("cic_interp_bank: NCH must be at least 1");
   end
   if (ORDER < 1) begin : g_bad_order
      $error("cic_interp_bank: ORDER must be at least 1");
   end
   if (DW < 2) begin : g_bad_dw
      $error("cic_interp_bank: DW must be at least 2");
   end
   if (((2**GAIN_W) - 1) >= ACCW) begin : g_bad_shift
      $error("cic_interp_bank: shift range exceeds accumulator width");
   end
   if (DROPW < 1) begin : g_bad_drop
      $error("cic_interp_bank: DROPW must be at least 1");
   end

   cic_cfg_t staged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged <= CFG_UNITY;
      end else if (stage_we) begin
         staged <= cic_cfg_t'(stage_data);
      end
   end

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic                   clr;
      cic_cfg_t               cfg;
      logic                   slot_full;
      logic [DW-1:0]          slot_dat;
      logic [DW-1:0]          xhold;
      logic [DW-1:0]          x_sel;
      logic [DW-1:0]          smp;
      logic [DW-1:0]          yv;
      logic signed [ACCW-1:0] acc;
      logic                   bnd;
      logic                   ready;
      logic                   emit;
      logic [DROPW-1:0]       drops;
      logic                   ov;
      logic [DW-1:0]          od;

      assign clr   = apply_we && apply_mask[ch];
      assign smp   = smp_data[ch*DW +: DW];
      assign x_sel = slot_full ? slot_dat : xhold;
      assign emit  = frame_tick && ready && (bnd || cont_mask[ch]);

      cic_rate_ctr #(
         .ORDER (ORDER)
      ) i_rate (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clr),
         .tick    (frame_tick),
         .rate_m1 (rate_minus1(cfg)),
         .bnd     (bnd),
         .ready   (ready)
      );

      cic_core #(
         .DW    (DW),
         .ORDER (ORDER),
         .ACCW  (ACCW)
      ) i_core (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .tick  (frame_tick),
         .bnd   (bnd),
         .x_in  (x_sel),
         .acc   (acc)
      );

      cic_gain_sat #(
         .DW     (DW),
         .ACCW   (ACCW),
         .SHW    (GAIN_W),
         .SAT_EN (1'b1)
      ) i_gain (
         .acc   (acc),
         .shamt (cfg.gain),
         .y     (yv)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg       <= CFG_UNITY;
            slot_full <= 1'b0;
            slot_dat  <= '0;
            xhold     <= '0;
            drops     <= '0;
            ov        <= 1'b0;
            od        <= '0;
         end else begin
            ov <= 1'b0;
            if (clr) begin
               cfg       <= staged;
               xhold     <= '0;
               slot_full <= smp_valid[ch];
               if (smp_valid[ch]) begin
                  slot_dat <= smp;
               end
            end else begin
               if (emit) begin
                  ov <= 1'b1;
                  od <= yv;
               end
               if (bnd) begin
                  xhold     <= x_sel;
                  slot_full <= smp_valid[ch];
                  if (smp_valid[ch]) begin
                     slot_dat <= smp;
                  end
               end else if (smp_valid[ch]) begin
                  if (slot_full) begin
                     drops <= drops + 1'b1;
                  end else begin
                     slot_full <= 1'b1;
                     slot_dat  <= smp;
                  end
               end
            end
         end
      end

      assign out_valid[ch]                  = ov;
      assign out_data[ch*DW +: DW]          = od;
      assign drop_count[ch*DROPW +: DROPW]  = drops;
   end

endmodule

// File: rtl/cic_interp_chk.sv
module cic_interp_chk #(
   parameter int NCH   = 4,
   parameter int DW    = 16,
   parameter int DROPW = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 frame_tick,
   input logic                 apply_we,
   input logic [NCH-1:0]       apply_mask,
   input logic [NCH-1:0]       smp_valid,
   input logic [NCH-1:0]       out_valid,
   input logic [NCH*DW-1:0]    out_data,
   input logic [NCH*DROPW-1:0] drop_count
);

   // R8
   pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|out_valid) |-> $past(frame_tick));

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
      // R4
      apply_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (apply_we && apply_mask[ch]) |=> !out_valid[ch]);

      // R8
      data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid[ch] |-> $stable(out_data[ch*DW +: DW]));

      // R9
      drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(drop_count[ch*DROPW +: DROPW]) |-> $past(smp_valid[ch]));

      // R9
      drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(drop_count[ch*DROPW +: DROPW]) |->
            (drop_count[ch*DROPW +: DROPW] == $past(drop_count[ch*DROPW +: DROPW]) + 1'b1));
   end

endmodule

bind cic_interp_bank cic_interp_chk #(
   .NCH   (NCH),
   .DW    (DW),
   .DROPW (DROPW)
) i_cic_interp_chk (.*);

// File: tb/test_cic_interp_bank.sv
module test_cic_interp_bank;
   import cic_interp_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NCH   = 2;
   localparam int DW    = 16;
   localparam int DROPW = 8;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 frame_tick = 1'b0;
   logic                 stage_we = 1'b0;
   logic [CFG_W-1:0]     stage_data = '0;
   logic                 apply_we = 1'b0;
   logic [NCH-1:0]       apply_mask = '0;
   logic [NCH-1:0]       cont_mask = '0;
   logic [NCH-1:0]       smp_valid = '0;
   logic [NCH*DW-1:0]    smp_data = '0;
   logic [NCH-1:0]       out_valid;
   logic [NCH*DW-1:0]    out_data;
   logic [NCH*DROPW-1:0] drop_count;

   int errors = 0;
   int checks = 0;
   int d0;

   cic_interp_bank #(
      .NCH   (NCH),
      .DW    (DW),
      .DROPW (DROPW)
   ) i_cic_interp_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_tick (frame_tick),
      .stage_we   (stage_we),
      .stage_data (stage_data),
      .apply_we   (apply_we),
      .apply_mask (apply_mask),
      .cont_mask  (cont_mask),
      .smp_valid  (smp_valid),
      .smp_data   (smp_data),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .drop_count (drop_count)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] cfgw(input int mant, input int rexp, input int gain);
      return 16'((gain << 10) | (rexp << 6) | mant);
   endfunction

   function automatic int pat(input int k);
      if (k == 5) return 16'hFFFF;
      if (k == 6) return 0;
      return (k * 40503) & 16'hFFFF;
   endfunction

   function automatic int ov(input int ch);
      return int'(out_valid[ch]);
   endfunction

   function automatic int od(input int ch);
      return int'(out_data[ch*DW +: DW]);
   endfunction

   function automatic int dc(input int ch);
      return int'(drop_count[ch*DROPW +: DROPW]);
   endfunction

   task automatic put(input int ch, input int x);
      @(negedge clk);
      smp_valid[ch] = 1'b1;
      smp_data[ch*DW +: DW] = DW'(x);
      @(negedge clk);
      smp_valid[ch] = 1'b0;
   endtask

   task automatic tick();
      repeat (2) @(negedge clk);
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
   endtask

   task automatic tick_smp(input int ch, input int x);
      repeat (2) @(negedge clk);
      frame_tick = 1'b1;
      smp_valid[ch] = 1'b1;
      smp_data[ch*DW +: DW] = DW'(x);
      @(negedge clk);
      frame_tick = 1'b0;
      smp_valid[ch] = 1'b0;
   endtask

   task automatic apply(input logic [NCH-1:0] mask, input logic [15:0] cfg, input bit with_tick);
      @(negedge clk);
      stage_we = 1'b1;
      stage_data = cfg;
      @(negedge clk);
      stage_we = 1'b0;
      apply_we = 1'b1;
      apply_mask = mask;
      frame_tick = with_tick;
      @(negedge clk);
      apply_we = 1'b0;
      frame_tick = 1'b0;
   endtask

   // ticks for channel 1 with first-valid and value checks at one tick
   task automatic run_ch1(input int n, input int at, input int exp, input string req);
      for (int t = 1; t <= n; t++) begin
         tick();
         if (t < at) begin
            check(ov(1) == 0, "R4", ov(1), 0);
         end else if (t == at) begin
            check(ov(1) == 1, "R4", ov(1), 1);
            if (exp >= 0) check(od(1) == exp, req, od(1), exp);
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check(out_valid == '0, "R1", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == '0, "R1", out_valid, 0);
      check(out_data == '0, "R1", out_data, 0);
      check(drop_count == '0, "R1", drop_count, 0);

      // R5 unity transparency with R4 settling at R = 1
      apply(2'b11, cfgw(0, 0, 0), 1'b0);
      for (int k = 1; k <= 12; k++) begin
         put(0, pat(k));
         put(1, pat(k + 40));
         tick();
         if (k < 4) begin
            check(ov(0) == 0, "R4", ov(0), 0);
            check(ov(1) == 0, "R4", ov(1), 0);
         end else begin
            check(ov(0) == 1, "R5", ov(0), 1);
            check(od(0) == pat(k), "R5", od(0), pat(k));
            check(od(1) == pat(k + 40), "R5", od(1), pat(k + 40));
         end
      end
      repeat (3) @(negedge clk);
      check(ov(0) == 0, "R8", ov(0), 0);
      check(od(0) == pat(12), "R8", od(0), pat(12));

      // R11 no sample in a period: previous one reused
      tick();
      check(ov(0) == 1 && od(0) == pat(12), "R11", od(0), pat(12));

      // R2 staging alone does nothing
      @(negedge clk);
      stage_we = 1'b1;
      stage_data = cfgw(3, 0, 6);
      @(negedge clk);
      stage_we = 1'b0;
      put(0, 1234);
      tick();
      check(ov(0) == 1 && od(0) == 1234, "R2", od(0), 1234);

      // R2 mask, R3 period, R6 gain: ch1 R=4 g=6, ch0 untouched
      apply(2'b10, cfgw(3, 0, 6), 1'b0);
      put(1, 1000);
      for (int t = 1; t <= 17; t++) begin
         put(0, pat(t + 80));
         tick();
         check(ov(0) == 1 && od(0) == pat(t + 80), "R2", od(0), pat(t + 80));
         if (t == 13 || t == 17) begin
            check(ov(1) == 1, "R3", ov(1), 1);
            check(od(1) == 1000, "R6", od(1), 1000);
         end else begin
            check(ov(1) == 0, "R3", ov(1), 0);
         end
      end

      // R8 continuous output on every tick
      cont_mask = 2'b10;
      for (int t = 18; t <= 20; t++) begin
         tick();
         check(ov(1) == 1 && od(1) == 1000, "R8", od(1), 1000);
      end

      // R9 second sample in one period is dropped
      put(1, 2000);
      put(1, 3000);
      check(dc(1) == 1, "R9", dc(1), 1);
      for (int t = 21; t <= 33; t++) tick();
      check(od(1) == 2000, "R9", od(1), 2000);
      check(dc(1) == 1, "R9", dc(1), 1);

      // R10 sample together with the boundary tick
      cont_mask = 2'b00;
      apply(2'b10, cfgw(3, 0, 6), 1'b0);
      d0 = dc(1);
      tick_smp(1, 4000);
      check(dc(1) == d0, "R10", dc(1), d0);
      put(1, 5000);
      check(dc(1) == d0 + 1, "R10", dc(1), d0 + 1);
      for (int t = 2; t <= 17; t++) begin
         tick();
         if (t == 13) check(ov(1) == 1 && od(1) == 3937, "R10", od(1), 3937);
         if (t == 14) check(ov(1) == 0, "R8", ov(1), 0);
         if (t == 17) check(ov(1) == 1 && od(1) == 4000, "R10", od(1), 4000);
      end

      // R6 R = 8 from mantissa 1, exponent 2, shift 9
      apply(2'b10, cfgw(1, 2, 9), 1'b0);
      put(1, 777);
      run_ch1(25, 25, -1, "R4");
      for (int t = 26; t <= 33; t++) tick();
      check(ov(1) == 1 && od(1) == 777, "R6", od(1), 777);

      // R7 saturation: R = 4, shift 0
      apply(2'b10, cfgw(3, 0, 0), 1'b0);
      put(1, 2000);
      run_ch1(13, 13, 65535, "R7");

      // R6 shift 8 at R = 4: 1001*64 >> 8
      apply(2'b10, cfgw(3, 0, 8), 1'b0);
      put(1, 1001);
      run_ch1(13, 13, 250, "R6");

      // R3 apply coinciding with a frame tick: that tick is ignored
      apply(2'b10, cfgw(0, 0, 0), 1'b1);
      put(1, 4321);
      for (int t = 1; t <= 4; t++) begin
         tick();
         if (t < 4) check(ov(1) == 0, "R3", ov(1), 0);
         else check(ov(1) == 1 && od(1) == 4321, "R3", od(1), 4321);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule